// File: doc/BRIEF.md
# Serial Bit Timing and Data Recovery

This block takes a stream of hard decisions coming out of a frequency-shift demodulator and turns it into a clean bit stream. Alongside the stream it gives one pulse per bit. It runs on a fixed reference clock of nominally 10 MHz.

A divider derives a sample tick from the reference. An optional smoothing stage cleans the incoming level. It is a first-order recursive accumulator feeding a slicer with hysteresis. Because it is advanced on the sample tick, its time constant follows the programmed bit rate without extra setup. A phase tracker counts 29 sample ticks per bit. It nudges its count whenever the cleaned level changes. At the centre of each bit it emits a one-cycle strobe together with the sampled bit.

The tracker has a fast and a slow gain. Gain selection is either manual or automatic. In automatic mode the tracker starts fast and drops to slow once lock is declared.

Two configuration bytes control the block. Each is loaded by its own one-cycle write pulse.
- The rate byte holds the prescaler bit in bit 7 and the divider value R in bits 6..0.
- The filter byte holds:
  - the automatic-gain enable in bit 7;
  - the manual gain select in bit 6;
  - the filter select in bit 4;
  - two spare control bits (bits 5 and 3) and a 3-bit quality threshold (bits 2..0). These are held for neighbouring logic and do not affect this block.

Top module: `brx_clk_recovery`

## Requirements
- R1: After reset the rate byte is 0x13 and the filter byte is 0x94 (automatic gain on, manual select slow, digital filter on, threshold 4). `bit_stb` and `locked` are 0, `bit_data` is 0 and `fast_trk` is 1. With a constant input the strobe repeats every 580 clocks.
- R2: The sample tick period is (R+1)·(1+7·cs) reference clocks. With no level change on the input, `bit_stb` repeats every 29 sample ticks.
- R3: In the rate byte, bit 7 is cs and bits 6..0 are R. Setting bit 7 stretches the tick period by exactly 8.
- R4: Filter byte bits 5, 3 and 2..0 appear on `side_cfg` as {bit5, bit3, bit2..0} from the cycle after the write. They do not change tracking.
- R5: A level change seen at tick phase p (counted 0..28) gives a phase error of p for p ≤ 14 and p−29 otherwise. The count is corrected by that error clamped to ±3 ticks in fast mode and ±1 tick in slow mode. A change seen 9 ticks after the centre therefore shortens that bit to 26 ticks (fast) or 28 ticks (slow).
- R6: With filter byte bit 7 = 0, `fast_trk` equals filter byte bit 6 (1 = fast, 0 = slow).
- R7: With filter byte bit 7 = 1, `fast_trk` is 1 while unlocked and 0 while locked.
- R8: `locked` rises after 8 consecutive level changes whose phase error is within ±1 tick. A change with a larger error restarts the count. Fewer than 8 changes never lock.
- R9: Any write to either configuration byte clears `locked` on the next cycle. It also clears the lock count.
- R10: `bit_stb` is one cycle wide. `bit_data` carries the transmitted bit sequence in order, both with the digital filter (filter byte bit 4 = 1) and with it bypassed (bit 4 = 0).
- R11: The digital filter updates on each sample tick. Its slicer goes high above 5/8 of full scale and low below 3/8. An input pulse of 3 ticks or fewer against a steady level does not change `bit_data`.
- R12: With the loop locked in slow mode, a transmitter running about 0.9 % slow (117 instead of 116 clocks per bit at R=3) is tracked with no bit errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 10 MHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Demodulated hard bit, asynchronous to clk |
| rate_wr | input | 1 | Load pulse for the rate byte |
| rate_byte | input | 8 | Rate byte: cs in bit 7, R in bits 6..0 |
| filt_wr | input | 1 | Load pulse for the filter byte |
| filt_byte | input | 8 | Filter byte: auto gain, manual gain, spare, filter select, spare, threshold |
| bit_stb | output | 1 | One-cycle pulse at bit centre |
| bit_data | output | 1 | Retimed data bit, valid with and after `bit_stb` |
| locked | output | 1 | Phase tracker lock flag |
| fast_trk | output | 1 | 1 while the tracker uses the fast gain |
| side_cfg | output | 5 | Held spare bits and threshold for neighbouring logic |

## Verification
Faults in different parts of the block show up at the ports in different ways and at different speeds:
- **Divider.** A wrong divider load or prescaler shows as a wrong gap between two strobes on the very first bit after a write.
- **Phase corrector.** A wrong clamp or a wrong sign of correction shows as a wrong length for the one bit containing a single level change. Over a stream it shows as retimed data slipping a bit within a few bits.
- **Lock counter or gain selector.** A fault here shows in `locked` and `fast_trk` within a dozen level changes.
- **Filter.** A fault in the accumulator or the slicer shows as a retimed bit that disagrees with the transmitted stream, or as a short pulse leaking into `bit_data` at the next strobe.

// File: rtl/brx_pkg.sv
package brx_pkg;

  localparam int SPB    = 29;  // sample ticks per bit
  localparam int CENTER = 14;  // strobe phase

  typedef struct packed {
    logic       cs;
    logic [6:0] r;
  } rate_cfg_t;

  typedef struct packed {
    logic       al;
    logic       ml;
    logic       sp5;
    logic       sf;
    logic       sp3;
    logic [2:0] thr;
  } filt_cfg_t;

  localparam logic [7:0] RATE_RST = 8'h13;
  localparam logic [7:0] FILT_RST = 8'h94;

endpackage

// File: rtl/brx_cfg_regs.sv
module brx_cfg_regs
  import brx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rate_wr,
  input  logic [7:0] rate_byte,
  input  logic      filt_wr,
  input  logic [7:0] filt_byte,
  output rate_cfg_t rate_cfg,
  output filt_cfg_t filt_cfg,
  output logic      cfg_chg
);

  logic [7:0] rate_q, rate_d;
  logic [7:0] filt_q, filt_d;

  always_comb begin
    rate_d = rate_wr ? rate_byte : rate_q;
    filt_d = filt_wr ? filt_byte : filt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_RST;
      filt_q <= FILT_RST;
    end else begin
      rate_q <= rate_d;
      filt_q <= filt_d;
    end
  end

  assign rate_cfg = rate_cfg_t'(rate_q);
  assign filt_cfg = filt_cfg_t'(filt_q);
  assign cfg_chg  = rate_wr | filt_wr;

endmodule

// File: rtl/brx_tick_gen.sv
module brx_tick_gen #(
  parameter int R_W     = 7,
  parameter int PRE_DIV = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           cs,
  input  logic [R_W-1:0] r,
  output logic           tick
);

  localparam int PRE_W = $clog2(PRE_DIV);
  localparam int CNT_W = R_W + PRE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, base, lim;

  always_comb begin
    base  = {{PRE_W{1'b0}}, r} + CNT_W'(1);
    lim   = (cs ? (base << PRE_W) : base) - CNT_W'(1);
    tick  = (cnt_q == lim);
    cnt_d = (restart || tick) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/brx_data_filter.sv
module brx_data_filter #(
  parameter int ACC_W = 8,
  parameter int SHIFT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic tick,
  input  logic dig_en,
  output logic dout
);

  localparam logic [ACC_W-1:0] FULL = '1;
  localparam logic [ACC_W-1:0] HI_T = ACC_W'((2 ** ACC_W) * 5 / 8);
  localparam logic [ACC_W-1:0] LO_T = ACC_W'((2 ** ACC_W) * 3 / 8);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             out_q, out_d;
  logic signed [ACC_W:0] diff, step;

  always_comb begin
    diff  = $signed({1'b0, (din ? FULL : '0)}) - $signed({1'b0, acc_q});
    step  = diff >>> SHIFT;
    acc_d = acc_q;
    out_d = out_q;
    if (!dig_en) begin
      out_d = din;
    end else if (tick) begin
      acc_d = acc_q + step[ACC_W-1:0];
      if (acc_d > HI_T)      out_d = 1'b1;
      else if (acc_d < LO_T) out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      out_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      out_q <= out_d;
    end
  end

  assign dout = out_q;

endmodule

// File: rtl/brx_phase_loop.sv
module brx_phase_loop #(
  parameter int SPB       = 29,
  parameter int CENTER    = 14,
  parameter int FAST_STEP = 3,
  parameter int SLOW_STEP = 1,
  parameter int LOCK_CNT  = 8,
  parameter int LOCK_TOL  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic d,
  input  logic fast,
  input  logic clr_lock,
  output logic bit_stb,
  output logic bit_data,
  output logic locked,
  output logic [$clog2(SPB)-1:0] ph
);

  localparam int PH_W = $clog2(SPB);
  localparam int LK_W = $clog2(LOCK_CNT + 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            prev_q, prev_d;
  logic            stb_q, stb_d, dat_q, dat_d;
  logic [LK_W-1:0] lk_q, lk_d;
  logic            lock_q, lock_d;
  logic            trans;
  int              p, err, gain, corr, n;

  always_comb begin
    p     = int'(ph_q);
    trans = tick && (d != prev_q);
    err   = (p <= CENTER) ? p : p - SPB;
    gain  = fast ? FAST_STEP : SLOW_STEP;
    if (err > gain)       corr = gain;
    else if (err < -gain) corr = -gain;
    else                  corr = err;
    n = p + 1 - (trans ? corr : 0);
    if (n >= SPB)   n = n - SPB;
    else if (n < 0) n = n + SPB;

    ph_d   = tick ? PH_W'(n) : ph_q;
    prev_d = tick ? d : prev_q;
    stb_d  = tick && (p == CENTER);
    dat_d  = stb_d ? d : dat_q;

    lk_d   = lk_q;
    lock_d = lock_q;
    if (clr_lock) begin
      lk_d   = '0;
      lock_d = 1'b0;
    end else if (trans) begin
      if (err <= LOCK_TOL && err >= -LOCK_TOL) begin
        if (int'(lk_q) == LOCK_CNT - 1) lock_d = 1'b1;
        else                            lk_d   = lk_q + LK_W'(1);
      end else begin
        lk_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      prev_q <= 1'b0;
      stb_q  <= 1'b0;
      dat_q  <= 1'b0;
      lk_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      prev_q <= prev_d;
      stb_q  <= stb_d;
      dat_q  <= dat_d;
      lk_q   <= lk_d;
      lock_q <= lock_d;
    end
  end

  assign bit_stb  = stb_q;
  assign bit_data = dat_q;
  assign locked   = lock_q;
  assign ph       = ph_q;

endmodule

// File: rtl/brx_clk_recovery.sv
module brx_clk_recovery
  import brx_pkg::*;
#(
  parameter int ACC_W     = 8,
  parameter int FLT_SHIFT = 2,
  parameter int LOCK_CNT  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic       rate_wr,
  input  logic [7:0] rate_byte,
  input  logic       filt_wr,
  input  logic [7:0] filt_byte,
  output logic       bit_stb,
  output logic       bit_data,
  output logic       locked,
  output logic       fast_trk,
  output logic [4:0] side_cfg
);

  localparam int PH_W = $clog2(SPB);

  logic [1:0]      rst_pipe;
  logic            rst_int_n;
  logic [1:0]      din_pipe;
  rate_cfg_t       rate_cfg;
  filt_cfg_t       filt_cfg;
  logic            cfg_chg, tick, dflt, lock_w;
  logic [PH_W-1:0] ph_dbg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) din_pipe <= 2'b00;
    else            din_pipe <= {din_pipe[0], din};
  end

  brx_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_int_n),
    .rate_wr(rate_wr), .rate_byte(rate_byte),
    .filt_wr(filt_wr), .filt_byte(filt_byte),
    .rate_cfg(rate_cfg), .filt_cfg(filt_cfg), .cfg_chg(cfg_chg)
  );

  brx_tick_gen #(.R_W(7), .PRE_DIV(8)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .restart(rate_wr),
    .cs(rate_cfg.cs), .r(rate_cfg.r), .tick(tick)
  );

  brx_data_filter #(.ACC_W(ACC_W), .SHIFT(FLT_SHIFT)) u_flt (
    .clk(clk), .rst_n(rst_int_n), .din(din_pipe[1]), .tick(tick),
    .dig_en(filt_cfg.sf), .dout(dflt)
  );

  always_comb fast_trk = filt_cfg.al ? !lock_w : filt_cfg.ml;

  brx_phase_loop #(
    .SPB(SPB), .CENTER(CENTER), .FAST_STEP(3), .SLOW_STEP(1),
    .LOCK_CNT(LOCK_CNT), .LOCK_TOL(1)
  ) u_loop (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .d(dflt), .fast(fast_trk),
    .clr_lock(cfg_chg), .bit_stb(bit_stb), .bit_data(bit_data),
    .locked(lock_w), .ph(ph_dbg)
  );

  assign locked   = lock_w;
  assign side_cfg = {filt_cfg.sp5, filt_cfg.sp3, filt_cfg.thr};

endmodule

// File: rtl/brx_clk_recovery_chk.sv
module brx_clk_recovery_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rate_wr,
  input logic       filt_wr,
  input logic [7:0] filt_byte,
  input logic       bit_stb,
  input logic       locked,
  input logic       fast_trk,
  input logic       al,
  input logic [4:0] ph
);

  p_stb_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  p_lock_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_wr || filt_wr) |=> !locked);

  p_manual_gain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_wr && !filt_byte[7]) |=> (fast_trk == $past(filt_byte[6])));

  p_auto_slow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(locked) && al) |-> !fast_trk);

  p_lock_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !$past(rate_wr || filt_wr));

  p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph < 5'd29);

endmodule

bind brx_clk_recovery brx_clk_recovery_chk chk_i (
  .clk(clk), .rst_n(rst_int_n), .rate_wr(rate_wr), .filt_wr(filt_wr),
  .filt_byte(filt_byte), .bit_stb(bit_stb), .locked(locked),
  .fast_trk(fast_trk), .al(filt_cfg.al), .ph(ph_dbg)
);

// File: tb/brx_clk_recovery_tb_top.sv
`timescale 1ns/1ps
module brx_clk_recovery_tb_top;

  logic       clk = 1'b0;
  logic       rst_n, din, rate_wr, filt_wr;
  logic [7:0] rate_byte, filt_byte;
  logic       bit_stb, bit_data, locked, fast_trk;
  logic [4:0] side_cfg;

  int     vectors = 0;
  int     fails   = 0;
  longint cyc     = 0;
  logic   sb_en   = 1'b0;
  string  sb_tag  = "R10";
  int     exp_q[$];
  logic [15:0] lfsr;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  brx_clk_recovery dut_i (
    .clk(clk), .rst_n(rst_n), .din(din),
    .rate_wr(rate_wr), .rate_byte(rate_byte),
    .filt_wr(filt_wr), .filt_byte(filt_byte),
    .bit_stb(bit_stb), .bit_data(bit_data), .locked(locked),
    .fast_trk(fast_trk), .side_cfg(side_cfg)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_rate(input logic [7:0] b);
    rate_byte = b; rate_wr = 1'b1;
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  task automatic write_filt(input logic [7:0] b);
    filt_byte = b; filt_wr = 1'b1;
    @(negedge clk);
    filt_wr = 1'b0;
  endtask

  task automatic wait_stb(output longint t);
    do @(negedge clk); while (!bit_stb);
    t = cyc;
  endtask

  task automatic measure_gap(input longint exp, input string tag);
    longint t0, t1;
    wait_stb(t0);
    wait_stb(t0);
    wait_stb(t1);
    check((t1 - t0) == exp, tag, t1 - t0, exp);
  endtask

  // driver: one bit on the line, expected item pushed to the scoreboard
  task automatic send_bit(input logic b, input int period);
    din = b;
    if (sb_en) exp_q.push_back(int'(b));
    repeat (period) @(negedge clk);
  endtask

  task automatic next_rand(output logic b);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    b = lfsr[0];
  endtask

  task automatic run_stream(input int period, input int n_pre, input int n_pay, input string tag);
    logic b;
    for (int i = 0; i < n_pre; i++) send_bit(logic'(i % 2), period);
    check(locked == 1'b1, "R8", locked, 1);
    exp_q.delete();
    sb_tag = tag;
    sb_en  = 1'b1;
    for (int i = 0; i < n_pay; i++) begin
      next_rand(b);
      send_bit(b, period);
    end
    sb_en = 1'b0;
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  // monitor: pop and compare on each strobe
  always @(negedge clk) begin
    if (sb_en && bit_stb && exp_q.size() > 0) begin
      int e;
      e = exp_q.pop_front();
      check(int'(bit_data) == e, sb_tag, bit_data, e);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    longint t0, t1;
    rst_n = 1'b0; din = 1'b0; rate_wr = 1'b0; filt_wr = 1'b0;
    rate_byte = 8'h00; filt_byte = 8'h00; lfsr = 16'hACE1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(bit_stb == 1'b0, "R1", bit_stb, 0);
    check(locked == 1'b0, "R1", locked, 0);
    check(bit_data == 1'b0, "R1", bit_data, 0);
    check(fast_trk == 1'b1, "R1", fast_trk, 1);
    check(side_cfg == 5'b00100, "R1", side_cfg, 5'b00100);
    measure_gap(580, "R1");

    // R2 / R3 divider
    write_rate(8'h00); measure_gap(29, "R2");
    write_rate(8'h02); measure_gap(87, "R2");
    write_rate(8'h80); measure_gap(232, "R3");
    write_rate(8'h81); measure_gap(464, "R3");

    // R4 held fields
    write_filt(8'hAF);
    check(side_cfg == 5'b11111, "R4", side_cfg, 5'b11111);
    write_filt(8'hC0);
    check(side_cfg == 5'b00000, "R4", side_cfg, 0);

    // R10 bypass filter, auto gain
    write_rate(8'h00);
    write_filt(8'h80);
    run_stream(29, 40, 64, "R10");
    check(fast_trk == 1'b0, "R7", fast_trk, 0);
    write_filt(8'h80);
    check(locked == 1'b0, "R9", locked, 0);
    check(fast_trk == 1'b1, "R7", fast_trk, 1);
    for (int i = 0; i < 4; i++) send_bit(logic'(i % 2), 29);
    check(locked == 1'b0, "R8", locked, 0);
    for (int i = 0; i < 12; i++) send_bit(logic'(i % 2), 29);
    check(locked == 1'b1, "R8", locked, 1);
    write_rate(8'h00);
    check(locked == 1'b0, "R9", locked, 0);

    // R10 / R11 digital filter
    write_filt(8'h90);
    run_stream(29, 40, 64, "R11");

    // R11 short pulse rejection
    din = 1'b0;
    repeat (100) @(negedge clk);
    din = 1'b1;
    repeat (3) @(negedge clk);
    din = 1'b0;
    for (int i = 0; i < 3; i++) begin
      wait_stb(t0);
      check(bit_data == 1'b0, "R11", bit_data, 0);
    end

    // R5 / R6 correction size, manual gain, bypass filter
    write_filt(8'h40);
    check(fast_trk == 1'b1, "R6", fast_trk, 1);
    din = 1'b0;
    repeat (80) @(negedge clk);
    wait_stb(t0);
    repeat (4) @(negedge clk);
    din = 1'b1;
    wait_stb(t1);
    check((t1 - t0) == 26, "R5", t1 - t0, 26);

    write_filt(8'h00);
    check(fast_trk == 1'b0, "R6", fast_trk, 0);
    repeat (80) @(negedge clk);
    wait_stb(t0);
    repeat (4) @(negedge clk);
    din = 1'b0;
    wait_stb(t1);
    check((t1 - t0) == 28, "R5", t1 - t0, 28);

    // R12 rate offset tolerance, locked in slow mode
    write_rate(8'h03);
    write_filt(8'h80);
    run_stream(117, 40, 48, "R12");
    check(fast_trk == 1'b0, "R12", fast_trk, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule